// File: doc/BRIEF.md
# Programmable-Phase External Bus Controller

This block is the master side of a non-multiplexed external parallel bus that has separate active-low read and write strobes. An internal host hands it one request at a time through a valid/ready handshake. A request carries an address, write data and a direction bit. The controller then runs the request on the external bus as a fixed sequence of five timed phases. Each phase length comes from its own configuration input and is counted in bus clock cycles.

The controller is a six-state machine. The states are `ST_IDLE`, `ST_ADDR`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD` and `ST_RECOV`, and it moves through them in that order:

- `ST_IDLE` goes to `ST_ADDR` when a request is accepted.
- Each of the next four states goes to its successor when its own phase count expires.
- `ST_RECOV` returns to `ST_IDLE` when the recovery count expires.

A single down-counter times every phase. It is reloaded with the next phase's field at each transition. The timing fields are copied when a request is accepted, so a change made during an access applies to the next access. Read data is captured on the clock edge that ends the strobe phase and is returned with a one-cycle completion pulse. The address-latch-enable pin exists only so the bus has its usual pin set, and it is held low at all times.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1, `bus_oe` and `done_pulse` are 0, and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the recovery phase ends, and `req_valid` has no effect during that time.
- R3: The address phase lasts `cfg_addr_len`+1 cycles (1 to 4). In this phase `bus_addr` shows the accepted address and `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are 1.
- R4: The data setup phase lasts `cfg_setup_len`+1 cycles (1 to 4). In this phase `bus_cs_n` is 0 and both strobes are 1. On a write, `bus_wdata` shows the accepted data.
- R5: The strobe phase lasts `cfg_strobe_len`+1 cycles (1 to 16) with `bus_cs_n` 0. During it `bus_rd_n` is 0 on a read (`req_write`=0) or `bus_wr_n` is 0 on a write (`req_write`=1), never both.
- R6: The hold phase lasts `cfg_hold_len`+1 cycles (1 to 4). In this phase `bus_cs_n` is 0, both strobes are 1, and the address and write data are unchanged.
- R7: The recovery phase lasts `cfg_recov_len`+1 cycles (1 to 16) with `bus_cs_n` 1 and `req_ready` 0. After it the controller returns to idle.
- R8: On a read, the value on `bus_rdata` at the rising edge that ends the strobe phase is the value presented on `done_rdata`.
- R9: `done_pulse` is 1 for exactly one cycle, the last cycle of the hold phase.
- R10: `bus_oe` is 1 only on writes, from the first setup cycle through the last hold cycle. It is 0 for the whole of a read.
- R11: `bus_ale` is 0 in every cycle.
- R12: All five timing fields are sampled when the request is accepted. Changing the `cfg_*` inputs during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_len | input | 2 | Address phase length minus one |
| cfg_setup_len | input | 2 | Data setup phase length minus one |
| cfg_strobe_len | input | 4 | Strobe phase length minus one |
| cfg_hold_len | input | 2 | Hold phase length minus one |
| cfg_recov_len | input | 4 | Recovery phase length minus one |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ale | output | 1 | Address latch enable, always 0 |
| bus_addr | output | ADDR_W | External address |
| bus_wdata | output | DATA_W | External write data |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rdata | input | DATA_W | External read data |

## Verification
The first address-phase cycle is visible one clock after the accepting edge. Each later phase begins on the edge after the previous phase's last cycle. The completion pulse and captured read data are visible in the last hold cycle, which is the hold-phase count of cycles after the read was sampled. When a request is issued, the bench builds a queue holding one expected output vector per cycle for the whole access, using only the five field values plus one for each phase length. It pops one entry at every falling edge and compares all outputs against it, so every phase boundary is checked in the exact cycle it is due. Read data is changed on every falling edge, so the captured value identifies the single edge at which sampling took place.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    // Field widths of the short (1..4) and long (1..16) phase counts.
    localparam int SHORT_W = 2;
    localparam int LONG_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_RECOV  = 3'd5
    } ebc_state_e;

    typedef struct packed {
        logic [LONG_W-1:0]  recov;
        logic [SHORT_W-1:0] hold;
        logic [LONG_W-1:0]  strobe;
        logic [SHORT_W-1:0] setup;
        logic [SHORT_W-1:0] addr;
    } ebc_timing_t;

endpackage

// File: rtl/ebc_phase_cnt.sv
module ebc_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  ebc_timing_t        timing_i,
    input  logic               cnt_zero_i,
    output ebc_state_e         state_o,
    output logic               accept_o,
    output logic               phase_end_o,
    output logic               cnt_load_o,
    output logic [LONG_W-1:0]  cnt_val_o,
    output logic               cnt_run_o,
    output logic               req_ready_o,
    output logic               done_o
);

    localparam int PAD_W = LONG_W - SHORT_W;

    ebc_state_e  state_q, state_d;
    ebc_timing_t tm_q;

    assign accept_o    = (state_q == ST_IDLE) && req_valid_i;
    assign phase_end_o = (state_q != ST_IDLE) && cnt_zero_i;
    assign cnt_run_o   = (state_q != ST_IDLE);
    assign req_ready_o = (state_q == ST_IDLE);
    assign done_o      = (state_q == ST_HOLD) && phase_end_o;
    assign state_o     = state_q;

    // State register and timing snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tm_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                tm_q <= timing_i;
            end
        end
    end

    // Next state and counter reload
    always_comb begin
        state_d    = state_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d    = ST_ADDR;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = {{PAD_W{1'b0}}, timing_i.addr};
                end
            end
            ST_ADDR: begin
                if (phase_end_o) begin
                    state_d    = ST_SETUP;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = {{PAD_W{1'b0}}, tm_q.setup};
                end
            end
            ST_SETUP: begin
                if (phase_end_o) begin
                    state_d    = ST_STROBE;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = tm_q.strobe;
                end
            end
            ST_STROBE: begin
                if (phase_end_o) begin
                    state_d    = ST_HOLD;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = {{PAD_W{1'b0}}, tm_q.hold};
                end
            end
            ST_HOLD: begin
                if (phase_end_o) begin
                    state_d    = ST_RECOV;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = tm_q.recov;
                end
            end
            ST_RECOV: begin
                if (phase_end_o) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // R2
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !req_ready_o);

    // R9
    done_then_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_RECOV));

    // R7
    recov_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RECOV) && (state_q != ST_RECOV) |-> (state_q == ST_IDLE));

endmodule

// File: rtl/ebc_drive.sv
module ebc_drive
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ebc_state_e        state_i,
    input  logic              accept_i,
    input  logic              phase_end_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              bus_cs_n_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_oe_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              capture;

    assign capture = (state_i == ST_STROBE) && phase_end_i && !wr_q;

    // Request snapshot and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept_i) begin
                wr_q    <= req_write_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
            if (capture) begin
                rdata_q <= bus_rdata_i;
            end
        end
    end

    // Pin decode from the current state
    always_comb begin
        bus_cs_n_o = 1'b1;
        bus_rd_n_o = 1'b1;
        bus_wr_n_o = 1'b1;
        bus_oe_o   = 1'b0;
        unique case (state_i)
            ST_SETUP: begin
                bus_cs_n_o = 1'b0;
                bus_oe_o   = wr_q;
            end
            ST_STROBE: begin
                bus_cs_n_o = 1'b0;
                bus_rd_n_o = wr_q;
                bus_wr_n_o = !wr_q;
                bus_oe_o   = wr_q;
            end
            ST_HOLD: begin
                bus_cs_n_o = 1'b0;
                bus_oe_o   = wr_q;
            end
            default: begin
                bus_cs_n_o = 1'b1;
            end
        endcase
    end

    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wdata_q;
    assign rdata_o     = rdata_q;

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n_o |-> bus_wr_n_o);

    // R5
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n_o || !bus_wr_n_o) |-> !bus_cs_n_o);

    // R10
    oe_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> bus_rd_n_o);

    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n_o && $past(!bus_cs_n_o)) |-> $stable(bus_addr_o));

    // R4
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o)) |-> $stable(bus_wdata_o));

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHORT_W-1:0] cfg_addr_len,
    input  logic [SHORT_W-1:0] cfg_setup_len,
    input  logic [LONG_W-1:0]  cfg_strobe_len,
    input  logic [SHORT_W-1:0] cfg_hold_len,
    input  logic [LONG_W-1:0]  cfg_recov_len,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               done_pulse,
    output logic [DATA_W-1:0]  done_rdata,
    output logic               bus_cs_n,
    output logic               bus_ale,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_oe,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    input  logic [DATA_W-1:0]  bus_rdata
);

    ebc_timing_t       timing;
    ebc_state_e        state;
    logic              accept;
    logic              phase_end;
    logic              cnt_load;
    logic [LONG_W-1:0] cnt_val;
    logic              cnt_run;
    logic              cnt_zero;

    assign timing.addr   = cfg_addr_len;
    assign timing.setup  = cfg_setup_len;
    assign timing.strobe = cfg_strobe_len;
    assign timing.hold   = cfg_hold_len;
    assign timing.recov  = cfg_recov_len;

    // Non-multiplexed operation: the latch enable is never driven high.
    assign bus_ale = 1'b0;

    ebc_phase_cnt #(
        .CNT_W (LONG_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .run_i      (cnt_run),
        .zero_o     (cnt_zero)
    );

    ebc_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .timing_i    (timing),
        .cnt_zero_i  (cnt_zero),
        .state_o     (state),
        .accept_o    (accept),
        .phase_end_o (phase_end),
        .cnt_load_o  (cnt_load),
        .cnt_val_o   (cnt_val),
        .cnt_run_o   (cnt_run),
        .req_ready_o (req_ready),
        .done_o      (done_pulse)
    );

    ebc_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) drive_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .accept_i    (accept),
        .phase_end_i (phase_end),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .bus_rdata_i (bus_rdata),
        .bus_cs_n_o  (bus_cs_n),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_oe_o    (bus_oe),
        .bus_rd_n_o  (bus_rd_n),
        .bus_wr_n_o  (bus_wr_n),
        .rdata_o     (done_rdata)
    );

endmodule

// File: tb/ext_bus_ctrl_tb_top.sv
module ext_bus_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 24;
    localparam int DW         = 16;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_addr_len = '0;
    logic [1:0]    cfg_setup_len = '0;
    logic [3:0]    cfg_strobe_len = '0;
    logic [1:0]    cfg_hold_len = '0;
    logic [3:0]    cfg_recov_len = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done_pulse;
    logic [DW-1:0] done_rdata;
    logic          bus_cs_n;
    logic          bus_ale;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_oe;
    logic          bus_rd_n;
    logic          bus_wr_n;
    logic [DW-1:0] bus_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_len(cfg_addr_len), .cfg_setup_len(cfg_setup_len),
        .cfg_strobe_len(cfg_strobe_len), .cfg_hold_len(cfg_hold_len),
        .cfg_recov_len(cfg_recov_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done_pulse(done_pulse), .done_rdata(done_rdata),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_oe(bus_oe), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_rdata(bus_rdata)
    );

    // One expected output vector per bus cycle.
    typedef struct {
        bit            cs_n, rd_n, wr_n, oe, rdy, done, cap, chk, w;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          expq[$];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] exp_rd = '0;

    task automatic chk(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    function automatic exp_t mk(bit cs_n, bit rd_n, bit wr_n, bit oe, bit rdy,
                                string tag);
        exp_t e;
        e.cs_n = cs_n; e.rd_n = rd_n; e.wr_n = wr_n; e.oe = oe; e.rdy = rdy;
        e.done = 1'b0; e.cap = 1'b0; e.chk = 1'b0; e.w = 1'b0;
        e.addr = '0; e.data = '0; e.tag = tag;
        return e;
    endfunction

    // Compare one cycle at the falling edge, then present fresh read data.
    task automatic step();
        exp_t e;
        @(negedge clk);
        if (expq.size() != 0) e = expq.pop_front();
        else e = mk(1, 1, 1, 0, 1, "R2");
        chk(e.tag, "cs_n", longint'(bus_cs_n), longint'(e.cs_n));
        chk(e.tag, "rd_n", longint'(bus_rd_n), longint'(e.rd_n));
        chk(e.tag, "wr_n", longint'(bus_wr_n), longint'(e.wr_n));
        chk("R10", "oe", longint'(bus_oe), longint'(e.oe));
        chk("R2", "ready", longint'(req_ready), longint'(e.rdy));
        chk("R9", "done", longint'(done_pulse), longint'(e.done));
        chk("R11", "ale", longint'(bus_ale), 0);
        if (e.chk) begin
            chk(e.tag, "addr", longint'(bus_addr), longint'(e.addr));
            if (e.w) chk(e.tag, "wdata", longint'(bus_wdata), longint'(e.data));
        end
        if (e.done && !e.w) chk("R8", "rdata", longint'(done_rdata), longint'(exp_rd));
        bus_rdata = DW'($urandom);
        if (e.cap) exp_rd = bus_rdata;
    endtask

    task automatic push_phase(int n, exp_t base, bit last_done, bit last_cap);
        for (int i = 0; i < n; i++) begin
            exp_t e = base;
            if (i == n - 1) begin
                e.done = last_done;
                e.cap  = last_cap;
            end
            expq.push_back(e);
        end
    endtask

    task automatic do_access(bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                             int t1, int t2, int t3, int t4, int t5,
                             string ovr, bit keep_valid);
        exp_t e;
        while (expq.size() != 0) step();
        step();
        cfg_addr_len   = 2'(t1);
        cfg_setup_len  = 2'(t2);
        cfg_strobe_len = 4'(t3);
        cfg_hold_len   = 2'(t4);
        cfg_recov_len  = 4'(t5);
        req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
        // R3 address phase
        e = mk(1, 1, 1, 0, 0, (ovr != "") ? ovr : "R3");
        e.chk = 1'b1; e.w = 1'b0; e.addr = a;
        push_phase(t1 + 1, e, 0, 0);
        // R4 setup phase
        e = mk(0, 1, 1, w, 0, (ovr != "") ? ovr : "R4");
        e.chk = 1'b1; e.w = w; e.addr = a; e.data = d;
        push_phase(t2 + 1, e, 0, 0);
        // R5 strobe phase
        e = mk(0, w, !w, w, 0, (ovr != "") ? ovr : "R5");
        e.chk = 1'b1; e.w = w; e.addr = a; e.data = d;
        push_phase(t3 + 1, e, 0, !w);
        // R6 hold phase
        e = mk(0, 1, 1, w, 0, (ovr != "") ? ovr : "R6");
        e.chk = 1'b1; e.w = w; e.addr = a; e.data = d;
        push_phase(t4 + 1, e, 1, 0);
        // R7 recovery phase
        e = mk(1, 1, 1, 0, 0, (ovr != "") ? ovr : "R7");
        e.w = w;
        push_phase(t5 + 1, e, 0, 0);
        step();
        if (!keep_valid) req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d; req_write = !w;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) expq.push_back(mk(1, 1, 1, 0, 1, "R1"));
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) expq.push_back(mk(1, 1, 1, 0, 1, "R1"));
        while (expq.size() != 0) step();

        // Shortest and longest phases, both directions
        do_access(1, 24'h00A5A5, 16'h1234, 0, 0, 0, 0, 0, "", 0);
        do_access(0, 24'h123456, 16'h0000, 0, 0, 0, 0, 0, "", 0);
        do_access(1, 24'hFFFFFF, 16'hBEEF, 3, 3, 15, 3, 15, "", 0);
        do_access(0, 24'h800001, 16'h0000, 3, 3, 15, 3, 15, "", 0);
        do_access(0, 24'h0F0F0F, 16'h0000, 1, 2, 5, 3, 2, "", 0);
        do_access(1, 24'h3C3C3C, 16'h5AA5, 2, 1, 9, 0, 4, "", 0);

        // R2: request held valid while busy must not start a second access
        do_access(1, 24'h777777, 16'hC0DE, 1, 1, 12, 1, 6, "", 1);
        for (int i = 0; i < 10; i++) step();
        req_valid = 1'b0;

        // R12: timing inputs changed mid-access do not affect it
        do_access(0, 24'hABCDEF, 16'h0000, 3, 0, 2, 1, 1, "R12", 0);
        cfg_addr_len = 2'd0; cfg_setup_len = 2'd3; cfg_strobe_len = 4'd15;
        cfg_hold_len = 2'd3; cfg_recov_len = 4'd0;
        do_access(1, 24'h010203, 16'h4455, 0, 3, 1, 2, 0, "R12", 0);
        cfg_strobe_len = 4'd7; cfg_recov_len = 4'd9;

        while (expq.size() != 0) step();
        for (int i = 0; i < 4; i++) step();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule